// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a read or write burst on a double-data-rate memory. A controller pulses a start strobe together with the starting column address, a burst-length selection (four or eight beats) and an ordering selection (sequential or interleaved). On the next cycle the block presents beat 0. It then steps to the next beat on each cycle in which the advance enable is high.

Every address of a burst stays inside the aligned block that the upper column bits select. A four-beat burst wraps within a group of four columns. An eight-beat burst wraps within a group of eight columns. Sequential eight-beat bursts count around within each half of the group and then swap halves. Interleaved bursts XOR the beat index into the starting low bits. The length and ordering are captured at the start strobe, so they cannot change during a burst. The last-beat flag marks the final address.

Top module: `burst_col_seq`

## Requirements
- R1: While idle, a high `start_i` is accepted. On the next cycle `valid_o` is 1 and `col_o` equals the `col_i` sampled with the strobe (beat 0). `len8_i` and `ilv_i` are captured at that edge.
- R2: `len8_i`=1 selects an eight-beat burst and `len8_i`=0 selects a four-beat burst. A burst presents exactly that many addresses.
- R3: Four-beat sequential (`ilv_i`=0): at beat i, `col_o[1:0]` = (start[1:0] + i) mod 4.
- R4: Four-beat interleaved (`ilv_i`=1): at beat i, `col_o[1:0]` = start[1:0] XOR i.
- R5: Eight-beat sequential: at beat i, `col_o[1:0]` = (start[1:0] + i) mod 4 and `col_o[2]` = start[2] XOR (i >= 4). For example, start 1 gives 1,2,3,0,5,6,7,4.
- R6: Eight-beat interleaved: at beat i, `col_o[2:0]` = start[2:0] XOR i.
- R7: During a burst, the bits of `col_o` above the beat field stay equal to those of the start address. That means bits 2 and up for four beats, and bits 3 and up for eight beats.
- R8: While `adv_i` is 0 during a burst, `col_o`, `valid_o` and `last_o` hold their values.
- R9: `last_o` is 1 exactly while the final address of the burst is presented. After that beat is advanced, `valid_o` is 0 on the next cycle.
- R10: A `start_i` that arrives while `valid_o` is 1 is ignored, and the running burst continues with its own addresses.
- R11: After reset, `valid_o` and `last_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a new burst |
| col_i | input | COL_W | Starting column address |
| len8_i | input | 1 | 1 = eight beats, 0 = four beats |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| adv_i | input | 1 | Advance to the next beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A burst beat is being presented |
| last_o | output | 1 | The current beat is the final one |

## Verification
The bench runs every starting low-bit pattern under both lengths and both orderings, with varied upper bits. It catches a sequential eight-beat burst that counts straight through modulo 8 instead of wrapping by nibble, and a four-beat burst that lets a carry reach bit 2 and leave its aligned block. Bursts with inserted stall cycles expose a design that advances without the enable or misplaces the last-beat flag by one beat. A start strobe fired mid-burst catches a design that reloads and so restarts the address sequence.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;
   localparam int BEAT_W = 3;

   typedef enum logic {
      LEN_FOUR  = 1'b0,
      LEN_EIGHT = 1'b1
   } burst_len_e;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } burst_ord_e;

   function automatic logic [BEAT_W-1:0] final_beat(input burst_len_e len);
      return (len == LEN_EIGHT) ? BEAT_W'(7) : BEAT_W'(3);
   endfunction
endpackage

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
   import burst_col_seq_pkg::*;
#(
   parameter int CNT_W = BEAT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   input  logic             adv_i,
   input  burst_len_e       len_i,
   output logic [CNT_W-1:0] beat_o,
   output logic             busy_o,
   output logic             final_o
);
   logic [CNT_W-1:0] beat_q;
   logic             busy_q;

   if (CNT_W < BEAT_W) begin : g_bad_width
      $error("bcs_beat_ctr: CNT_W must cover eight beats");
   end

   assign final_o = busy_q && (beat_q == CNT_W'(final_beat(len_i)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
         busy_q <= 1'b0;
      end else if (launch_i) begin
         beat_q <= '0;
         busy_q <= 1'b1;
      end else if (busy_q && adv_i) begin
         if (final_o) begin
            beat_q <= '0;
            busy_q <= 1'b0;
         end else begin
            beat_q <= beat_q + CNT_W'(1);
         end
      end
   end

   assign beat_o = beat_q;
   assign busy_o = busy_q;
endmodule

// File: rtl/bcs_low_order.sv
module bcs_low_order
   import burst_col_seq_pkg::*;
(
   input  logic [BEAT_W-1:0] start_low_i,
   input  logic [BEAT_W-1:0] beat_i,
   input  burst_len_e        len_i,
   input  burst_ord_e        ord_i,
   output logic [BEAT_W-1:0] low_o
);
   logic [BEAT_W-1:0] eff_beat;
   logic [BEAT_W-1:0] ilv_low;
   logic [BEAT_W-1:0] seq_low;
   logic [1:0]        nib_sum;

   // beat bit 2 only takes part in eight-beat bursts
   assign eff_beat = {beat_i[2] & (len_i == LEN_EIGHT), beat_i[1:0]};

   for (genvar k = 0; k < BEAT_W; k++) begin : g_ilv_bit
      assign ilv_low[k] = start_low_i[k] ^ eff_beat[k];
   end

   // nibble wrap: the sum of the low two bits never carries into bit 2
   assign nib_sum = start_low_i[1:0] + beat_i[1:0];
   assign seq_low = {start_low_i[2] ^ eff_beat[2], nib_sum};

   assign low_o = (ord_i == ORD_ILV) ? ilv_low : seq_low;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import burst_col_seq_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] col_i,
   input  logic             len8_i,
   input  logic             ilv_i,
   input  logic             adv_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);
   localparam int UPPER_W = COL_W - BEAT_W;

   if (COL_W < BEAT_W + 1) begin : g_bad_col
      $error("burst_col_seq: COL_W must exceed the beat field");
   end

   logic [COL_W-1:0]  base_q;
   burst_len_e        len_q;
   burst_ord_e        ord_q;
   logic              launch;
   logic [BEAT_W-1:0] beat;
   logic              busy;
   logic              final_beat_w;
   logic [BEAT_W-1:0] low;

   assign launch = start_i && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= LEN_FOUR;
         ord_q  <= ORD_SEQ;
      end else if (launch) begin
         base_q <= col_i;
         len_q  <= burst_len_e'(len8_i);
         ord_q  <= burst_ord_e'(ilv_i);
      end
   end

   bcs_beat_ctr #(.CNT_W(BEAT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch_i(launch),
      .adv_i   (adv_i),
      .len_i   (len_q),
      .beat_o  (beat),
      .busy_o  (busy),
      .final_o (final_beat_w)
   );

   bcs_low_order u_order (
      .start_low_i(base_q[BEAT_W-1:0]),
      .beat_i     (beat),
      .len_i      (len_q),
      .ord_i      (ord_q),
      .low_o      (low)
   );

   assign col_o   = {base_q[COL_W-1 -: UPPER_W], low};
   assign valid_o = busy;
   assign last_o  = final_beat_w;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] col_i,
   input logic             len8_i,
   input logic             ilv_i,
   input logic             adv_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o
);
   p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && start_i) |=> (valid_o && col_o == $past(col_i)));

   p_upper_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o) |=> $stable(col_o[COL_W-1:3]));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !adv_i) |=> (valid_o && $stable(col_o) && $stable(last_o)));

   p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   p_last_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && adv_i) |=> !valid_o);

   p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && start_i) |=> valid_o);

   p_reset_r11: assert property (@(posedge clk)
      !rst_n |-> (!valid_o && !last_o));

   logic unused_ok;
   assign unused_ok = &{1'b0, len8_i, ilv_i};
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .col_i  (col_i),
   .len8_i (len8_i),
   .ilv_i  (ilv_i),
   .adv_i  (adv_i),
   .col_o  (col_o),
   .valid_o(valid_o),
   .last_o (last_o)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] col_i = '0;
   logic             len8_i = 1'b0;
   logic             ilv_i = 1'b0;
   logic             adv_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (.*);

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
                                                input bit l8, input bit il, input int i);
      logic [COL_W-1:0] r;
      int lo;
      r = s;
      if (il) begin
         lo = l8 ? (int'(s[2:0]) ^ i) : (int'(s[1:0]) ^ i);
         if (l8) r[2:0] = lo[2:0]; else r[1:0] = lo[1:0];
      end else begin
         lo = (int'(s[1:0]) + i) % 4;
         r[1:0] = lo[1:0];
         if (l8 && i >= 4) r[2] = ~s[2];
      end
      return r;
   endfunction

   function automatic string req_of(input bit l8, input bit il);
      if (!l8) return il ? "R4" : "R3";
      return il ? "R6" : "R5";
   endfunction

   // stall_at: beat index before which one idle cycle is inserted (-1 = none)
   // poke_at: beat index at which a stray start strobe is fired (-1 = none)
   task automatic run_burst(input logic [COL_W-1:0] s, input bit l8, input bit il,
                            input int stall_at, input int poke_at);
      int n;
      n = l8 ? 8 : 4;
      @(negedge clk);
      start_i = 1'b1; col_i = s; len8_i = l8; ilv_i = il; adv_i = 1'b0;
      @(posedge clk); #1;
      start_i = 1'b0; col_i = ~s; len8_i = ~l8; ilv_i = ~il;
      @(negedge clk);
      chk("R1 valid after start", valid_o, 1);
      chk("R1 beat0 address", col_o, s);
      for (int i = 0; i < n; i++) begin
         chk(req_of(l8, il), col_o, exp_col(s, l8, il, i));
         chk("R7 upper bits", col_o >> (l8 ? 3 : 2), s >> (l8 ? 3 : 2));
         chk("R9 last flag", last_o, (i == n - 1));
         chk("R2 valid within burst", valid_o, 1);
         if (i == stall_at) begin
            adv_i = 1'b0;
            @(negedge clk);
            chk("R8 hold address", col_o, exp_col(s, l8, il, i));
            chk("R8 hold last", last_o, (i == n - 1));
         end
         if (i == poke_at) begin
            start_i = 1'b1;
            col_i = s ^ 10'h2A5;
         end
         adv_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         adv_i = 1'b0;
         if (i == poke_at && i < n - 1)
            chk("R10 stray start ignored", col_o, exp_col(s, l8, il, i + 1));
      end
      chk("R9 valid drops after last", valid_o, 0);
      chk("R2 no extra beat", last_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset valid", valid_o, 0);
      chk("R11 reset last", last_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle valid", valid_o, 0);
      for (int up = 0; up < 4; up++) begin
         for (int lo = 0; lo < 8; lo++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
               logic [COL_W-1:0] s;
               s = COL_W'((up * 37 + 5) << 3) | COL_W'(lo);
               run_burst(s, cfg[1], cfg[0], (lo + cfg) % 8 - 1, -1);
            end
         end
      end
      run_burst(10'h3FF, 1'b1, 1'b0, 2, 1);
      run_burst(10'h001, 1'b0, 1'b1, -1, 0);
      run_burst(10'h155, 1'b1, 1'b1, 6, 5);
      run_burst(10'h203, 1'b0, 1'b0, 3, 2);
      repeat (2) @(negedge clk);
      chk("R9 stays idle", valid_o, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule